// File: doc/BRIEF.md
# Pin-Level I2C Target to Byte Command Bridge

This block is the target end of an I2C bus whose controller moves SCL and SDA by writing general-purpose pins. The system clock samples both lines. The block finds START and STOP conditions and assembles the bits clocked on SCL rising edges into bytes. It converts these into single-cycle commands on a simple byte-level device bus: begin transfer (with 7-bit address and direction), send byte, receive byte, controller-NACK notice and end transfer. The device side answers in the same cycle, with an accept flag for addresses and written bytes and with a data byte for reads.

The bridge also returns the level of the shared, wired-AND SDA line. That level is the target's own drive ANDed with the controller's last sampled SDA level. The target pulls the line low only for an accepted address or data byte, and for the bits of a byte being read that are 0. It releases the line on every SCL falling edge.

Top module: `i2c_pin_bridge`

## Requirements
- R1: After reset, `sda_o` is 1, no command pulses, and the bridge is idle: SCL rising edges before any START produce no command.
- R2: SDA falling while SCL is high is a START, including a repeated START. It starts collection of a new byte and forgets any latched address, so the next byte is an address. A repeated START issues no end-transfer.
- R3: SDA rising while SCL is high is a STOP. It pulses `end_o` only when an address is latched, then returns to idle.
- R4: An SDA change while SCL is low has no protocol effect, and neither does a level that stays the same.
- R5: Every SCL falling edge releases the target's drive, so `sda_o` follows the controller's SDA again.
- R6: While collecting a byte, each SCL rising edge shifts SDA in MSB first. On the ninth rising edge, the first byte after START pulses `begin_o` with `addr_o` = bits 7..1 and `rnw_o` = bit 0 (1 = read). Each later byte pulses `send_o` with the byte on `wdata_o`.
- R7: On the ninth edge, `ack_i` = 0 pulses `end_o` in the same cycle, returns to idle and leaves SDA released. `ack_i` = 1 pulls SDA low until the next SCL fall, then continues with reading if the address bit 0 was 1, or with the next written byte if it was 0.
- R8: On the first rising edge of a read byte, `recv_o` pulses and `rdata_i` is taken. The target drives that byte MSB first, one bit per rising edge for eight edges.
- R9: On the rising edge after a read byte, controller SDA low starts another read. SDA high pulses `nack_o`, and the target stays released until the next START or STOP.
- R10: `sda_o` equals the target's drive ANDed with the controller's last sampled SDA level.
- R11: At most one of `begin_o`, `send_o`, `recv_o`, `nack_o` pulses in a cycle, and each event gives exactly one pulse.
- R12: When a START or STOP arrives in the same sample as an SCL fall, both take effect: the condition changes state and the drive is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Controller SCL level |
| sda_i | input | 1 | Controller SDA level |
| sda_o | output | 1 | Resolved SDA level returned to the controller |
| begin_o | output | 1 | Begin-transfer command pulse |
| addr_o | output | 7 | Target address, valid with `begin_o` |
| rnw_o | output | 1 | Direction, 1 = read, valid with `begin_o` |
| send_o | output | 1 | Send-byte command pulse |
| wdata_o | output | 8 | Written byte, valid with `send_o` |
| recv_o | output | 1 | Receive-byte command pulse |
| rdata_i | input | 8 | Read byte from the device, sampled with `recv_o` |
| ack_i | input | 1 | Device accepts the address or byte, sampled with `begin_o`/`send_o` |
| nack_o | output | 1 | Controller NACKed a read byte |
| end_o | output | 1 | End-transfer command pulse |

## Verification
The synchronizers sample both lines together. A START or STOP can therefore land in the same cycle as an SCL falling edge, and the bridge must apply the condition and the drive release together. The bench provokes this by switching SDA and SCL at the same instant: from both high to both low for a START, and from SCL high and SDA low to SCL low and SDA high for a STOP. It judges the outcome by the next byte being taken as an address, and by an end-transfer pulse, in addition to the per-cycle comparison against the reference model.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBIT,
    ST_WACK,
    ST_RBIT,
    ST_CACK,
    ST_HUSH
  } bridge_state_e;
endpackage

// File: rtl/i2c_bridge_sync.sv
module i2c_bridge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= '1;
        else         pipe_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= '1;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bridge_events.sv
module i2c_bridge_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic sda_now_o,
  output logic sda_last_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  // SDA is judged against the SCL level held before this sample
  assign start_o    = scl_q &  sda_q & ~sda_s_i;
  assign stop_o     = scl_q & ~sda_q &  sda_s_i;
  assign rise_o     = ~scl_q &  scl_s_i;
  assign fall_o     =  scl_q & ~scl_s_i;
  assign sda_now_o  = sda_s_i;
  assign sda_last_o = sda_q;
endmodule

// File: rtl/i2c_bridge_proto.sv
module i2c_bridge_proto
  import i2c_bridge_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              begin_o,
  output logic              send_o,
  output logic              recv_o,
  output logic              nack_o,
  output logic              end_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              drive_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bridge_state_e     st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic              drv_q, drv_d;
  logic              av_q, av_d;
  logic              rnw_q, rnw_d;
  logic              rd_dir;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      buf_q <= '0;
      drv_q <= 1'b1;
      av_q  <= 1'b0;
      rnw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      buf_q <= buf_d;
      drv_q <= drv_d;
      av_q  <= av_d;
      rnw_q <= rnw_d;
    end

  assign rd_dir = av_q ? rnw_q : buf_q[0];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    buf_d   = buf_q;
    drv_d   = drv_q;
    av_d    = av_q;
    rnw_d   = rnw_q;
    begin_o = 1'b0;
    send_o  = 1'b0;
    recv_o  = 1'b0;
    nack_o  = 1'b0;
    end_o   = 1'b0;

    if (start_i) begin
      st_d  = ST_WBIT;
      cnt_d = '0;
      av_d  = 1'b0;
      drv_d = 1'b1;
    end else if (stop_i) begin
      end_o = av_q;
      av_d  = 1'b0;
      st_d  = ST_IDLE;
      drv_d = 1'b1;
    end

    if (fall_i) begin
      drv_d = 1'b1;
    end else if (rise_i) begin
      unique case (st_q)
        ST_WBIT: begin
          buf_d = {buf_q[BYTE_W-2:0], sda_i};
          drv_d = 1'b1;
          if (cnt_q == LAST_BIT) begin
            st_d  = ST_WACK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_WACK: begin
          if (!av_q) begin
            begin_o = 1'b1;
            av_d    = 1'b1;
            rnw_d   = buf_q[0];
          end else begin
            send_o  = 1'b1;
          end
          cnt_d = '0;
          if (!ack_i) begin
            end_o = 1'b1;
            av_d  = 1'b0;
            st_d  = ST_IDLE;
            drv_d = 1'b1;
          end else begin
            drv_d = 1'b0;
            st_d  = rd_dir ? ST_RBIT : ST_WBIT;
          end
        end
        ST_RBIT: begin
          if (cnt_q == '0) begin
            recv_o = 1'b1;
            drv_d  = rdata_i[BYTE_W-1];
            buf_d  = {rdata_i[BYTE_W-2:0], 1'b0};
          end else begin
            drv_d  = buf_q[BYTE_W-1];
            buf_d  = {buf_q[BYTE_W-2:0], 1'b0};
          end
          if (cnt_q == LAST_BIT) begin
            st_d  = ST_CACK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_CACK: begin
          drv_d = 1'b1;
          cnt_d = '0;
          if (sda_i) begin
            nack_o = 1'b1;
            st_d   = ST_HUSH;
          end else begin
            st_d   = ST_RBIT;
          end
        end
        default: drv_d = 1'b1;
      endcase
    end
  end

  assign byte_o  = buf_q;
  assign drive_o = drv_q;
endmodule

// File: rtl/i2c_pin_bridge.sv
module i2c_pin_bridge #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  localparam int ADDR_W     = BYTE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              begin_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rnw_o,
  output logic              send_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              recv_o,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              ack_i,
  output logic              nack_o,
  output logic              end_o
);
  logic [1:0]        pins_s;
  logic              evt_start, evt_stop, evt_rise, evt_fall;
  logic              sda_now, sda_last, tgt_drive;
  logic [BYTE_W-1:0] shift_byte;

  i2c_bridge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (pins_s)
  );

  i2c_bridge_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (pins_s[1]),
    .sda_s_i    (pins_s[0]),
    .start_o    (evt_start),
    .stop_o     (evt_stop),
    .rise_o     (evt_rise),
    .fall_o     (evt_fall),
    .sda_now_o  (sda_now),
    .sda_last_o (sda_last)
  );

  i2c_bridge_proto #(.BYTE_W(BYTE_W)) u_proto (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (evt_start),
    .stop_i  (evt_stop),
    .rise_i  (evt_rise),
    .fall_i  (evt_fall),
    .sda_i   (sda_now),
    .ack_i   (ack_i),
    .rdata_i (rdata_i),
    .begin_o (begin_o),
    .send_o  (send_o),
    .recv_o  (recv_o),
    .nack_o  (nack_o),
    .end_o   (end_o),
    .byte_o  (shift_byte),
    .drive_o (tgt_drive)
  );

  assign addr_o  = shift_byte[BYTE_W-1:1];
  assign rnw_o   = shift_byte[0];
  assign wdata_o = shift_byte;
  assign sda_o   = tgt_drive & sda_last;
endmodule

// File: rtl/i2c_bridge_chk.sv
module i2c_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic begin_i,
  input logic send_i,
  input logic recv_i,
  input logic nack_i,
  input logic end_i,
  input logic ack_i,
  input logic rise_i,
  input logic fall_i,
  input logic stop_i,
  input logic drive_i
);
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({begin_i, send_i, recv_i, nack_i}));                        // R11
  AST_CMD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i | send_i | recv_i | nack_i) |-> rise_i);                    // R6
  AST_END_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> (stop_i | begin_i | send_i));                              // R3
  AST_REFUSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((begin_i | send_i) && !ack_i) |-> end_i);                           // R7
  AST_ACK_PULLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((begin_i | send_i) && ack_i) |=> !drive_i);                         // R7
  AST_FALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> drive_i);                                                 // R5
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i |=> drive_i);                                                 // R9
endmodule

bind i2c_pin_bridge i2c_bridge_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .begin_i (begin_o),
  .send_i  (send_o),
  .recv_i  (recv_o),
  .nack_i  (nack_o),
  .end_i   (end_o),
  .ack_i   (ack_i),
  .rise_i  (evt_rise),
  .fall_i  (evt_fall),
  .stop_i  (evt_stop),
  .drive_i (tgt_drive)
);

// File: tb/i2c_pin_bridge_tb.sv
`timescale 1ns/1ps
module i2c_pin_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       ack = 1'b1;
  logic [7:0] rdat = 8'h00;
  logic       sda_o, begin_o, rnw_o, send_o, recv_o, nack_o, end_o;
  logic [6:0] addr_o;
  logic [7:0] wdata_o;

  always #2.5 clk = ~clk;

  i2c_pin_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o),
    .begin_o(begin_o), .addr_o(addr_o), .rnw_o(rnw_o), .send_o(send_o),
    .wdata_o(wdata_o), .recv_o(recv_o), .rdata_i(rdat), .ack_i(ack),
    .nack_o(nack_o), .end_o(end_o)
  );

  int n_cmp = 0, n_bad = 0;
  int c_begin = 0, c_send = 0, c_recv = 0, c_nack = 0, c_end = 0;
  int last_addr = -1, last_rnw = -1, last_wdata = -1;

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // states: 0 idle, 1 collect, 2 device answer, 3 read out, 4 controller answer, 5 silent
  int sq[$];
  int p_lvl, m_st, m_cnt, m_buf, m_drv, m_av, m_rnw;

  task automatic model_reset();
    sq = {3, 3};
    p_lvl = 3; m_st = 0; m_cnt = 0; m_buf = 0; m_drv = 1; m_av = 0; m_rnw = 0;
  endtask

  task automatic decide(input bit commit, output bit ob, output bit os,
                        output bit orc, output bit on, output bit oe);
    int now_lvl, st, cnt, bf, drv, av, rnw;
    bit scl_n, sda_n, scl_p, sda_p;
    now_lvl = sq[1];
    scl_n = now_lvl[1]; sda_n = now_lvl[0];
    scl_p = p_lvl[1];   sda_p = p_lvl[0];
    st = m_st; cnt = m_cnt; bf = m_buf; drv = m_drv; av = m_av; rnw = m_rnw;
    ob = 0; os = 0; orc = 0; on = 0; oe = 0;
    if (scl_p && sda_p != sda_n) begin
      drv = 1;
      if (!sda_n) begin st = 1; cnt = 0; av = 0; end
      else begin oe = (av != 0); av = 0; st = 0; end
    end
    if (scl_p && !scl_n) drv = 1;
    else if (!scl_p && scl_n) begin
      if (st == 1) begin
        bf = ((bf << 1) | sda_n) & 255; drv = 1; cnt++;
        if (cnt == 8) begin st = 2; cnt = 0; end
      end else if (st == 2) begin
        if (av == 0) begin ob = 1; av = 1; rnw = bf & 1; end
        else os = 1;
        cnt = 0;
        if (!ack) begin oe = 1; av = 0; st = 0; drv = 1; end
        else begin drv = 0; st = rnw ? 3 : 1; end
      end else if (st == 3) begin
        if (cnt == 0) begin orc = 1; bf = rdat; end
        drv = (bf >> 7) & 1;
        bf = (bf << 1) & 255;
        cnt++;
        if (cnt == 8) begin st = 4; cnt = 0; end
      end else if (st == 4) begin
        drv = 1; cnt = 0;
        if (sda_n) begin on = 1; st = 5; end else st = 3;
      end else drv = 1;
    end
    if (commit) begin
      m_st = st; m_cnt = cnt; m_buf = bf; m_drv = drv; m_av = av; m_rnw = rnw;
    end
  endtask

  always @(negedge clk) begin
    bit b, s, r, n, e;
    if (!rst_n) model_reset();
    else begin
      decide(1'b1, b, s, r, n, e);
      p_lvl = sq[1];
      void'(sq.pop_back());
      sq.push_front({30'd0, scl, sda});
      decide(1'b0, b, s, r, n, e);
      check("R6 begin_o", begin_o, b);
      check("R6 send_o", send_o, s);
      check("R8 recv_o", recv_o, r);
      check("R9 nack_o", nack_o, n);
      check("R3 end_o", end_o, e);
      check("R10 sda_o", sda_o, m_drv & p_lvl & 1);
      if (begin_o || send_o) check("R6 wdata_o", wdata_o, m_buf);
      if (begin_o || send_o || recv_o || nack_o)
        check("R11 single command", int'(begin_o) + send_o + recv_o + nack_o, 1);
      if (begin_o) begin c_begin++; last_addr = addr_o; last_rnw = rnw_o; end
      if (send_o) begin c_send++; last_wdata = wdata_o; end
      if (recv_o) c_recv++;
      if (nack_o) c_nack++;
      if (end_o)  c_end++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pins(input bit c, input bit d);
    scl = c; sda = d; hold(4);
  endtask

  task automatic bus_start();
    pins(1, 1); pins(1, 0); pins(0, 0);
  endtask

  task automatic bus_stop();
    pins(0, 0); pins(1, 0); pins(1, 1);
  endtask

  task automatic bus_bit(input bit d, output bit seen);
    pins(0, ~d); pins(0, d); pins(1, d);
    seen = sda_o;
    pins(0, d);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit acked);
    bit x;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], x);
    bus_bit(1'b1, x);
    acked = ~x;
  endtask

  task automatic read_byte(input bit cack, output logic [7:0] v);
    bit x;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, x); v[i] = x; end
    bus_bit(cack, x);
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit acked;
    logic [7:0] rv;
    int e0, b0;
    hold(3);
    check("R1 reset sda_o", sda_o, 1);
    check("R1 reset no pulse", int'(begin_o) + send_o + recv_o + nack_o + end_o, 0);
    rst_n = 1'b1;
    hold(3);

    // R1/R4: idle rises and SDA wiggles with SCL low
    pins(0, 1); pins(0, 0); pins(0, 1); pins(0, 0); pins(0, 1); pins(1, 1);
    pins(0, 1); pins(1, 1);
    check("R1 idle no command", c_begin + c_send + c_recv + c_nack + c_end, 0);
    check("R4 wiggle no command", sda_o, 1);

    // write transfer
    ack = 1'b1;
    bus_start();
    write_byte(8'h54, acked);
    check("R7 address acked low", acked, 1);
    check("R5 released after fall", sda_o, 1);
    check("R6 begin address", last_addr, 8'h2A);
    check("R6 begin direction", last_rnw, 0);
    write_byte(8'hA5, acked);
    check("R4 byte unaffected by low wiggles", last_wdata, 8'hA5);
    check("R6 send count", c_send, 1);
    bus_stop();
    check("R3 end after stop", c_end, 1);

    // read transfer
    rdat = 8'hC3;
    bus_start();
    write_byte(8'h55, acked);
    check("R6 read direction", last_rnw, 1);
    read_byte(1'b0, rv);
    check("R8 first read byte", rv, 8'hC3);
    rdat = 8'h3C;
    read_byte(1'b1, rv);
    check("R8 second read byte", rv, 8'h3C);
    check("R9 nack count", c_nack, 1);
    check("R8 recv count", c_recv, 2);
    read_byte(1'b1, rv);
    check("R9 released after nack", rv, 8'hFF);
    check("R9 no further receive", c_recv, 2);
    bus_stop();
    check("R3 end after read", c_end, 2);

    // refusal
    ack = 1'b0;
    b0 = c_begin;
    bus_start();
    write_byte(8'h90, acked);
    check("R7 refused not pulled", acked, 0);
    check("R7 refusal ends", c_end, 3);
    write_byte(8'h11, acked);
    check("R7 idle after refusal", c_send + c_begin - b0, 2);
    bus_stop();
    check("R3 no end without address", c_end, 3);

    // repeated START
    ack = 1'b1;
    b0 = c_begin;
    bus_start();
    write_byte(8'h20, acked);
    pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
    write_byte(8'h31, acked);
    check("R2 two begins", c_begin - b0, 2);
    check("R2 no end on restart", c_end, 3);
    check("R2 second address", last_addr, 8'h18);
    bus_stop();
    check("R3 end after restart", c_end, 4);

    // START alone then STOP
    bus_start();
    bus_stop();
    check("R3 start-stop no end", c_end, 4);

    // same-sample START + SCL fall, then STOP + SCL fall
    b0 = c_begin;
    pins(1, 1);
    pins(0, 0);
    write_byte(8'h40, acked);
    check("R12 start with fall", c_begin - b0, 1);
    check("R12 start with fall address", last_addr, 8'h20);
    e0 = c_end;
    pins(0, 0); pins(1, 0);
    pins(0, 1);
    check("R12 stop with fall", c_end - e0, 1);
    check("R12 released", sda_o, 1);
    pins(1, 1);
    check("R12 idle after stop", c_end - e0, 1);

    hold(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule